// File: doc/BRIEF.md
# Filtered Edge-Sensitive Pin Interrupt Port

This block watches a port of eight raw pins and turns a qualified edge on any of them into one shared interrupt request. Every pin first crosses a two-flop synchronizer. It then runs through a pulse-width qualifier that counts bus-clock samples at the pin's active level. The active level is chosen per pin: a polarity bit of 1 selects a rising edge (high is active), and 0 selects a falling edge (low is active). A pulse that holds the active level for at least four consecutive samples sets a sticky flag for that pin. Shorter pulses are discarded as glitches.

Software sees three registers through a plain write port and a combinational read port. These are the per-pin enable register, the polarity register, and the flag register, which is cleared by writing 1. The interrupt line is high while any flag and its enable are both set. A wake request follows the interrupt line whenever the low-power indication is high, so a core in stop or wait mode can be woken. The pins are only sampled, so sensing works the same whether the pad drives the pin or receives it. All register and pin ports are level-based control signals, with no valid/ready handshake and no back-pressure.

Top module: `pin_irq_port`

## Requirements
- R1: After reset, the enable, polarity and flag registers read 0, and irq and wake_req are low.
- R2: A pulse that holds the active level for 3 or fewer consecutive clock samples never sets a flag.
- R3: A pulse that holds the active level for 4 or more samples sets that pin's flag. Counting from the pin change, the flag becomes visible after the 6th rising clock edge (2 synchronizer stages plus 4 samples), and not before it.
- R4: Polarity bit i = 1 makes a high pulse active on pin i. Polarity bit i = 0 makes a low pulse active on pin i.
- R5: Flags are sticky. A write to address 2 clears each flag whose data bit is 1, and leaves every flag whose data bit is 0 unchanged.
- R6: When a flag is set and cleared in the same cycle, the flag ends up set.
- R7: irq is high exactly when (flags & enable) is non-zero. A disabled pin still sets its flag but does not drive irq.
- R8: wake_req is high exactly when irq and lp_mode are both high.
- R9: A pin held at the active level produces only one event. After that flag is cleared, it does not set again until the pin has shown at least one inactive sample and then 4 more active samples.
- R10: Writing a pin's polarity bit so that the pin's current level becomes active does not set a flag.
- R11: Read addresses 0, 1, 2 and 3 return the enable register, the polarity register, the flags and zero, respectively. Writes to addresses 0 and 1 load the enable and polarity registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw pin levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 enable, 1 polarity, 2 flag clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| lp_mode | input | 1 | Core is in a stop or wait state |
| irq | output | 1 | Shared interrupt request |
| wake_req | output | 1 | Wake-up request |

## Verification
The bench probes the edge of the glitch window with pulses of exactly 3 and 4 samples. A qualifier that was off by one would flag the 3-sample glitch or miss the 4-sample pulse. It also checks that the flag is still clear one edge before the 6th edge, which catches a missing synchronizer stage. A clear write is timed to land on the same edge as a set, and a design that gives priority to the clear loses the event. Pins are held active across a clear, and the polarity is flipped under a static pin. A filter that re-fires without an inactive sample, or that treats a polarity flip as an edge, raises flags that should stay clear.

// File: rtl/pip_pkg.sv
package pip_pkg;
  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_POLAR  = 2'd1,
    SEL_FLAGS  = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pip_sync.sv
module pip_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pip_filter.sv
module pip_filter #(
  parameter int QUAL_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic rise_sel,
  output logic qual
);
  localparam int CW = (QUAL_LEN > 2) ? $clog2(QUAL_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          rise_q;
  logic          active;
  logic          pol_flip;

  assign active   = rise_sel ? sample : ~sample;
  assign pol_flip = rise_sel != rise_q;
  assign qual     = active && armed_q && !pol_flip && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      rise_q  <= 1'b0;
    end else begin
      rise_q <= rise_sel;
      if (pol_flip) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (!active) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pip_flags.sv
module pip_flags #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] set_vec,
  input  logic [NPINS-1:0] clr_vec,
  output logic [NPINS-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/pin_irq_port.sv
module pin_irq_port
  import pip_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NPINS-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [NPINS-1:0] rd_data,
  input  logic             lp_mode,
  output logic             irq,
  output logic             wake_req
);
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] pol_q;
  logic [NPINS-1:0] flag_q;
  logic [NPINS-1:0] pin_s;
  logic [NPINS-1:0] qual_vec;
  logic [NPINS-1:0] clr_vec;
  reg_sel_e         wsel;
  reg_sel_e         rsel;

  assign wsel = reg_sel_e'(wr_addr);
  assign rsel = reg_sel_e'(rd_addr);

  pip_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (pin_s)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      pip_filter #(.QUAL_LEN(QUAL_LEN)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (pin_s[i]),
        .rise_sel (pol_q[i]),
        .qual     (qual_vec[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (wr_en) begin
      if (wsel == SEL_ENABLE) en_q  <= wr_data;
      if (wsel == SEL_POLAR)  pol_q <= wr_data;
    end
  end

  assign clr_vec = (wr_en && wsel == SEL_FLAGS) ? wr_data : '0;

  pip_flags #(.NPINS(NPINS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (qual_vec),
    .clr_vec (clr_vec),
    .flags   (flag_q)
  );

  always_comb begin
    unique case (rsel)
      SEL_ENABLE: rd_data = en_q;
      SEL_POLAR:  rd_data = pol_q;
      SEL_FLAGS:  rd_data = flag_q;
      default:    rd_data = '0;
    endcase
  end

  assign irq      = |(flag_q & en_q);
  assign wake_req = irq & lp_mode;
endmodule

// File: rtl/pin_irq_port_chk.sv
module pin_irq_port_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] flags,
  input logic [NPINS-1:0] en,
  input logic [NPINS-1:0] qual_vec,
  input logic             irq,
  input logic             wake_req,
  input logic             lp_mode
);
  // R3
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~$past(flags))) |-> (|$past(qual_vec)));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual_vec) |=> ((flags & $past(qual_vec)) == $past(qual_vec)));

  // R9
  single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|qual_vec) |=> ((qual_vec & $past(qual_vec)) == '0));

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(flags & en)));

  // R8
  wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (irq && lp_mode));
endmodule

bind pin_irq_port pin_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flags    (flag_q),
  .en       (en_q),
  .qual_vec (qual_vec),
  .irq      (irq),
  .wake_req (wake_req),
  .lp_mode  (lp_mode)
);

// File: tb/pin_irq_port_tb.sv
module pin_irq_port_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [1:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         lp_mode = 1'b0;
  logic         irq;
  logic         wake_req;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] exp_flags = '0;
  logic [N-1:0] exp_en = '0;
  logic [N-1:0] exp_pol = '0;

  always #2 clk = ~clk;

  pin_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .lp_mode(lp_mode), .irq(irq), .wake_req(wake_req)
  );

  function automatic logic exp_irq(input logic [N-1:0] f, input logic [N-1:0] e);
    return |(f & e);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rd_addr = a;
    #0.5 d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pulse the pin to its active level for k samples, then back to inactive
  task automatic pulse(input int i, input int k);
    @(negedge clk);
    pin_in[i] = exp_pol[i];
    repeat (k) @(negedge clk);
    pin_in[i] = ~exp_pol[i];
    if (k >= 4) exp_flags[i] = 1'b1;
    idle(8);
  endtask

  task automatic check_state(input string req);
    logic [N-1:0] d;
    rd(2'd2, d);
    check({req, " flags"}, d, exp_flags);
    check({req, " irq"}, irq, exp_irq(exp_flags, exp_en));
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd24681));
    idle(3);
    // R1 reset state
    rd(2'd0, d); check("R1 enable", d, '0);
    rd(2'd1, d); check("R1 polarity", d, '0);
    rd(2'd2, d); check("R1 flags", d, '0);
    check("R1 irq", irq, 1'b0);
    check("R1 wake", wake_req, 1'b0);
    rst_n = 1'b1;
    idle(2);
    // pins low are active under falling polarity after reset: no flag (R9 re-arm)
    idle(8);
    rd(2'd2, d); check("R9 no event without inactive sample", d, '0);

    // R11 register access
    exp_pol = 8'hFF; wr(2'd1, exp_pol);
    exp_en  = 8'h0F; wr(2'd0, exp_en);
    rd(2'd0, d); check("R11 enable readback", d, 8'h0F);
    rd(2'd1, d); check("R11 polarity readback", d, 8'hFF);
    rd(2'd3, d); check("R11 reserved reads zero", d, '0);
    idle(4);
    check_state("R10 polarity write to inactive level");

    // R2 glitch of 3 samples, R3 pulse of 4 samples
    pulse(0, 3); check_state("R2 three-sample glitch");
    pulse(0, 1); check_state("R2 one-sample glitch");
    pulse(0, 4); check_state("R3 four-sample pulse");

    // R5 W1C: zero bits unaffected
    wr(2'd2, 8'hFE); check_state("R5 clear other bits");
    wr(2'd2, 8'h01); exp_flags[0] = 1'b0; check_state("R5 clear own bit");

    // R3 timing: flag absent before 6th edge, present after; R6 clear on same edge
    @(negedge clk); pin_in[1] = 1'b1;
    repeat (5) @(negedge clk);
    rd_addr = 2'd2; #0.5;
    check("R3 flag not before sixth edge", rd_data[1], 1'b0);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h02;
    @(negedge clk); wr_en = 1'b0; #0.5;
    check("R6 set wins over clear", rd_data[1], 1'b1);
    exp_flags[1] = 1'b1;
    // R9 held active: clear, no re-set while still held
    idle(6);
    wr(2'd2, 8'h02); exp_flags[1] = 1'b0;
    idle(10);
    check_state("R9 held pin no second event");
    pin_in[1] = 1'b0; idle(6);
    pulse(1, 4); check_state("R9 re-armed after inactive");

    // R7 disabled pin sets flag but no irq; R8 wake
    wr(2'd2, 8'hFF); exp_flags = '0;
    pulse(6, 5); check_state("R7 disabled pin flag");
    check("R7 disabled no irq", irq, 1'b0);
    pulse(2, 4); check_state("R7 enabled pin irq");
    check("R8 wake low without lp", wake_req, 1'b0);
    lp_mode = 1'b1; #0.5; check("R8 wake with lp", wake_req, 1'b1);
    wr(2'd2, 8'h04); exp_flags[2] = 1'b0;
    #0.5; check("R8 wake drops with irq", wake_req, 1'b0);
    lp_mode = 1'b0;

    // R4 falling polarity on pin 3: idle high first
    exp_pol[3] = 1'b0; wr(2'd1, exp_pol);
    idle(4); pin_in[3] = 1'b1; idle(6);
    check_state("R10 polarity flip static pin");
    pulse(3, 4); check_state("R4 falling pulse");
    // R10 flip back to rising while pin is high: becomes active, no flag
    wr(2'd2, 8'h08); exp_flags[3] = 1'b0;
    exp_pol[3] = 1'b1; wr(2'd1, exp_pol);
    idle(10); check_state("R10 flip to active level");
    pin_in[3] = 1'b0; idle(6);

    // random phase
    for (int it = 0; it < 60; it++) begin
      int sel;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        exp_en = N'($urandom); wr(2'd0, exp_en);
      end else if (sel == 1) begin
        logic [N-1:0] m;
        m = N'($urandom);
        wr(2'd2, m); exp_flags &= ~m;
      end else begin
        int p;
        int k;
        p = $urandom_range(0, N-1);
        k = $urandom_range(1, 8);
        pulse(p, k);
      end
      check_state(it % 2 == 0 ? "R2 random" : "R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule